// File: doc/BRIEF.md
# Programmable Serial Clock Edge Generator

This block derives the serial clock for a flash command engine from the bus clock. A phase counter counts bus-clock ticks inside one serial-clock cycle whose length comes from a packed timing word. Three more fields of that word each pick one tick within the cycle:

- the tick at which the serial clock goes low,
- the tick at which it goes high,
- the tick at which read data should be captured.

Because the three ticks are chosen independently, the clock duty cycle and the capture point can be shifted relative to each other. The clock is not restricted to a plain even divide.

A sequencer raises `run` to clock bits and drops it to stop. While running, the block emits three one-cycle strobes:

- a shift strobe on the low-going tick, for launching the next output bit,
- a sample strobe on the capture tick,
- a bit-done pulse on the last tick of each cycle.

While stopped, the clock rests high, as SPI mode 3 needs. The usual setting is a cycle of 2·i ticks with the high-going edge at tick i and the low-going edge at tick 0, for i from 1 to 6. This gives a symmetric clock at the bus rate divided by 2i.

Top module: `sck_edge_gen`

## Requirements
- R1: During reset `sck` is 1 and `shift_stb`, `sample_stb` and `bit_done` are 0.
- R2: While `run` is 1 the phase counter starts at 0 in the first running cycle, counts up by one per cycle and wraps to 0 after phase P−1, where P is `timing[3:0]`. `bit_done` is 1 exactly in the cycles at phase P−1.
- R3: A period field of 0 or 1 behaves exactly as a period of 2.
- R4: `sck` becomes 0 in the cycle after a phase equal to the fall field `timing[15:12]`. It becomes 1 in the cycle after a phase equal to the rise field `timing[11:8]`. Otherwise `sck` holds its value.
- R5: When the rise and fall fields are equal, the high-going edge wins and `sck` stays 1.
- R6: `shift_stb` is 1 exactly in the running cycles whose phase equals the fall field.
- R7: `sample_stb` is 1 exactly in the running cycles whose phase equals the sample field `timing[19:16]`.
- R8: A rise, fall or sample field not below the effective period never produces that edge or strobe.
- R9: While `run` is 0 the three strobes are 0 and the counter is held at 0. `sck` is 1 from the second stopped cycle on. The next run starts again at phase 0.
- R10: With period 2i, rise i and fall 0 (i = 1..6), `sck` is high for i cycles and low for i cycles in every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Sequencer request to generate clock cycles |
| timing | input | 20 | Packed word: period [3:0], rise tick [11:8], fall tick [15:12], sample tick [19:16] |
| sck | output | 1 | Serial clock, resting high |
| shift_stb | output | 1 | One-cycle strobe at the low-going tick |
| sample_stb | output | 1 | One-cycle strobe at the capture tick |
| bit_done | output | 1 | One-cycle pulse at the last tick of each serial-clock cycle |

## Verification
The standard symmetric settings for every divider from 1 to 6 check the wrap point and the equal high and low halves at each rate. An asymmetric cycle with all three ticks in distinct places separates the fall field from the rise field and from the sample field, which a symmetric pattern cannot do. Period values 0 and 1, coincident rise and fall ticks, out-of-range tick fields and the largest period probe the clamp, the edge priority and the range limits. Every burst ends with a stop, so the return to a high idle clock and the restart at phase 0 are checked each time.

// File: rtl/sck_edge_gen.sv
module sck_edge_gen #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [5*FW-1:0] timing,
  output logic          sck,
  output logic          shift_stb,
  output logic          sample_stb,
  output logic          bit_done
);

  logic [FW-1:0] per_f, rise_f, fall_f, smp_f, last, cnt;
  logic          at_last, sck_q;

  assign per_f  = timing[FW-1:0];
  assign rise_f = timing[3*FW-1:2*FW];
  assign fall_f = timing[4*FW-1:3*FW];
  assign smp_f  = timing[5*FW-1:4*FW];

  assign last    = (per_f < FW'(2)) ? FW'(1) : per_f - FW'(1);
  assign at_last = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else if (!run) begin
      cnt   <= '0;
      sck_q <= 1'b1;
    end else begin
      cnt <= at_last ? '0 : cnt + FW'(1);
      if (cnt == rise_f)      sck_q <= 1'b1;
      else if (cnt == fall_f) sck_q <= 1'b0;
    end
  end

  assign sck        = sck_q;
  assign shift_stb  = run && (cnt == fall_f);
  assign sample_stb = run && (cnt == smp_f);
  assign bit_done   = run && at_last;

  AST_DONE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_done |=> (cnt == '0)); // R2

  AST_FALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_stb && (rise_f != fall_f)) |=> !sck); // R4

  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (cnt == rise_f)) |=> sck); // R5

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> sck); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0)); // R9

endmodule

// File: tb/test_sck_edge_gen.sv
`timescale 1ns/1ps
module test_sck_edge_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [19:0] timing = '0;
  logic        sck, shift_stb, sample_stb, bit_done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic  sck;
    logic  shf;
    logic  smp;
    logic  dn;
    string tag;
  } exp_t;

  exp_t q[$];
  logic s_model = 1'b1;

  always #2 clk = ~clk;

  sck_edge_gen i_sck_edge_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .timing(timing),
    .sck(sck), .shift_stb(shift_stb), .sample_stb(sample_stb), .bit_done(bit_done)
  );

  task automatic push(input logic s, input logic f, input logic m, input logic d, input string tag);
    exp_t e;
    e.sck = s; e.shf = f; e.smp = m; e.dn = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic burst(input int per, input int rise, input int fall, input int smp,
                       input int n, input string tag);
    int p;
    p = (per < 2) ? 2 : per;
    for (int j = 0; j < n; j++) begin
      int ph;
      @(negedge clk);
      timing = {4'(smp), 4'(fall), 4'(rise), 4'b0, 4'(per)};
      run = 1'b1;
      ph = j % p;
      push(s_model, ph == fall, ph == smp, ph == p - 1, tag);
      if (ph == rise) s_model = 1'b1;
      else if (ph == fall) s_model = 1'b0;
    end
    @(negedge clk);
    run = 1'b0;
    push(s_model, 1'b0, 1'b0, 1'b0, "R9");
    s_model = 1'b1;
    @(negedge clk);
    push(1'b1, 1'b0, 1'b0, 1'b0, "R9");
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if ({sck, shift_stb, sample_stb, bit_done} !== {e.sck, e.shf, e.smp, e.dn}) begin
          bad++;
          $display("FAIL %s: sck/shift/sample/done actual=%b%b%b%b expected=%b%b%b%b",
                   e.tag, sck, shift_stb, sample_stb, bit_done, e.sck, e.shf, e.smp, e.dn);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1;
    total++;
    if ({sck, shift_stb, sample_stb, bit_done} !== 4'b1000) begin
      bad++;
      $display("FAIL R1: actual=%b%b%b%b expected=1000", sck, shift_stb, sample_stb, bit_done);
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R10 and R2: symmetric settings for every divider
    for (int i = 1; i <= 6; i++) burst(2*i, i, 0, i, 6*i, "R10");
    // R3: clamped periods
    burst(0, 1, 0, 1, 6, "R3");
    burst(1, 1, 0, 0, 6, "R3");
    // R6 and R7 with R4: asymmetric placement
    burst(7, 5, 2, 6, 21, "R6");
    burst(7, 1, 4, 3, 14, "R7");
    // R5: coincident edges
    burst(5, 3, 3, 1, 15, "R5");
    // R8: fields beyond the period
    burst(4, 9, 12, 15, 12, "R8");
    burst(6, 2, 8, 10, 12, "R8");
    // R2 and R4 at the largest period
    burst(15, 14, 0, 7, 30, "R4");
    burst(3, 2, 0, 1, 9, "R2");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule